// File: doc/BRIEF.md
# Supply Switchover Control

This block chooses which source feeds a protected output rail: the main supply or a backup battery. It does not measure any voltage. It receives digitized comparator flags and returns switch enables. The flags are: the supply is under the reset threshold, the supply is more than 20 mV above the battery, the battery is more than 20 mV above the supply, and the raw power-fail comparator result. The switch enables drive external analog pass devices.

While the battery feeds the rail, the block is in backup mode. In backup mode it switches off the power-fail comparator and forces the power-fail output low. It also turns off the watchdog and holds the system reset asserted. The two hysteresis flags form a window about 40 mV wide. Inside that window the previous selection is kept, so a slowly falling supply does not make the switches chatter. Every change of source passes through a dead interval in which both switches are open.

Every flag is synchronized through `SYNC_STAGES` flops before it is used. The selection is registered. The length of the dead interval is set by `DEAD_CYCLES`.

Top module: `supply_switchover_ctrl`

## Requirements
- R1: When the synchronized supply-low flag is clear, the selection is the main supply on the next clock, whatever the two hysteresis flags say.
- R2: When supply-low is set, the battery-above flag is set and the supply-above flag is clear, the battery is selected: backup_o is 1 and, once the dead interval ends, sw_batt_o is 1.
- R3: When supply-low is set, the supply-above flag is set and the battery-above flag is clear, the main supply is selected.
- R4: When supply-low is set and neither hysteresis flag is set, the previous selection is held, whether it was the battery or the main supply.
- R5: When both hysteresis flags are set at once, which is an inconsistent input, the previous selection is held.
- R6: sw_main_o and sw_batt_o are never 1 in the same cycle. On every change of source, both are 0 for exactly DEAD_CYCLES cycles (default 1) before the new enable rises.
- R7: Outside backup mode, pfo_o equals the synchronized pf_ok_i, where 1 means the monitored input is above the reference, and pfcmp_en_o is 1. In backup mode, pfo_o is 0 and pfcmp_en_o is 0.
- R8: In backup mode, wdog_en_o is 0 and rst_hold_o is 1. Outside backup mode, wdog_en_o is 1 and rst_hold_o is 0.
- R9: During and right after reset, the outputs are: sw_main_o=1, sw_batt_o=0, backup_o=0, pfo_o=0, pfcmp_en_o=1, wdog_en_o=1 and rst_hold_o=0.
- R10: A flag change made just after a clock edge reaches backup_o SYNC_STAGES+1 edges later. The new switch enable rises DEAD_CYCLES edges after that (with the defaults, after 3 and 4 edges).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_low_i | input | 1 | Supply is under the reset threshold |
| vcc_over_bat_i | input | 1 | Supply is more than 20 mV above the battery |
| bat_over_vcc_i | input | 1 | Battery is more than 20 mV above the supply |
| pf_ok_i | input | 1 | Raw power-fail comparator, 1 when the input is above the reference |
| sw_main_o | output | 1 | Enable for the main-supply switch |
| sw_batt_o | output | 1 | Enable for the battery switch |
| backup_o | output | 1 | The battery is the selected source |
| pfo_o | output | 1 | Power-fail output, gated in backup mode |
| pfcmp_en_o | output | 1 | Enable for the power-fail comparator |
| wdog_en_o | output | 1 | Enable for the watchdog |
| rst_hold_o | output | 1 | Forces the system reset asserted |

## Verification
The bench goes after the hold window from both sides, the inconsistent case with both flags set, and a supply that recovers while the battery flag is still set. A design that treated the window as "select main" would drop the battery as soon as the supply passed the battery voltage; the same goes for a design that ranked the battery flag above supply-low. A monitor watches every cycle for overlapping enables and for a dead interval that is missing or has the wrong length, which is the result of an unguarded source change. A directed run counts the clock edges from a flag change to backup_o and to the new switch enable, to catch a missing or extra pipeline stage.

// File: rtl/swo_pkg.sv
package swo_pkg;
  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_BATT = 1'b1
  } src_e;

  typedef struct packed {
    logic vcc_low;
    logic vcc_over;
    logic bat_over;
    logic pf_ok;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);
endpackage

// File: rtl/swo_sync.sv
module swo_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [WIDTH-1:0] stg_q [STAGES];
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= '0;
          else         stg_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= '0;
          else         stg_q[i] <= stg_q[i-1];
        end
      end
    end
    assign q_o = stg_q[STAGES-1];
  end
endmodule

// File: rtl/swo_select.sv
module swo_select
  import swo_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t flags_i,
  output src_e   sel_d_o,
  output src_e   sel_q_o
);
  src_e sel_d, sel_q;

  // Priority: supply ok wins; inside the hysteresis window (or with inconsistent flags) hold.
  always_comb begin
    sel_d = sel_q;
    if (!flags_i.vcc_low)                           sel_d = SRC_MAIN;
    else if (flags_i.bat_over && !flags_i.vcc_over) sel_d = SRC_BATT;
    else if (flags_i.vcc_over && !flags_i.bat_over) sel_d = SRC_MAIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SRC_MAIN;
    else         sel_q <= sel_d;
  end

  assign sel_d_o = sel_d;
  assign sel_q_o = sel_q;
endmodule

// File: rtl/swo_sequencer.sv
module swo_sequencer
  import swo_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e sel_d_i,
  input  src_e sel_q_i,
  output logic sw_main_o,
  output logic sw_batt_o
);
  localparam int unsigned CNT_W = (DEAD_CYCLES < 1) ? 1 : $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] DEAD_LOAD = CNT_W'(DEAD_CYCLES);

  logic [CNT_W-1:0] dead_q, dead_d;
  logic             change;
  logic             main_q, batt_q;

  assign change = (sel_d_i != sel_q_i);

  always_comb begin
    if (change)           dead_d = DEAD_LOAD;
    else if (dead_q != 0) dead_d = dead_q - 1'b1;
    else                  dead_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dead_q <= '0;
      main_q <= 1'b1;
      batt_q <= 1'b0;
    end else begin
      dead_q <= dead_d;
      main_q <= (dead_d == 0) && (sel_d_i == SRC_MAIN);
      batt_q <= (dead_d == 0) && (sel_d_i == SRC_BATT);
    end
  end

  assign sw_main_o = main_q;
  assign sw_batt_o = batt_q;
endmodule

// File: rtl/swo_gating.sv
module swo_gating
  import swo_pkg::*;
(
  input  src_e sel_q_i,
  input  logic pf_ok_i,
  output logic backup_o,
  output logic pfo_o,
  output logic pfcmp_en_o,
  output logic wdog_en_o,
  output logic rst_hold_o
);
  logic in_backup;
  assign in_backup  = (sel_q_i == SRC_BATT);
  assign backup_o   = in_backup;
  assign pfo_o      = pf_ok_i & ~in_backup;
  assign pfcmp_en_o = ~in_backup;
  assign wdog_en_o  = ~in_backup;
  assign rst_hold_o = in_backup;
endmodule

// File: rtl/supply_switchover_ctrl.sv
module supply_switchover_ctrl
  import swo_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEAD_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_low_i,
  input  logic vcc_over_bat_i,
  input  logic bat_over_vcc_i,
  input  logic pf_ok_i,
  output logic sw_main_o,
  output logic sw_batt_o,
  output logic backup_o,
  output logic pfo_o,
  output logic pfcmp_en_o,
  output logic wdog_en_o,
  output logic rst_hold_o
);
  flags_t flags_raw, flags_s;
  src_e   sel_d, sel_q;
  logic   vcc_low_s, vcc_over_s, bat_over_s;

  assign flags_raw = '{vcc_low: vcc_low_i, vcc_over: vcc_over_bat_i,
                       bat_over: bat_over_vcc_i, pf_ok: pf_ok_i};

  swo_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (flags_raw),
    .q_o   (flags_s)
  );

  assign vcc_low_s  = flags_s.vcc_low;
  assign vcc_over_s = flags_s.vcc_over;
  assign bat_over_s = flags_s.bat_over;

  swo_select u_select (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(flags_s),
    .sel_d_o(sel_d),
    .sel_q_o(sel_q)
  );

  swo_sequencer #(.DEAD_CYCLES(DEAD_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_d_i  (sel_d),
    .sel_q_i  (sel_q),
    .sw_main_o(sw_main_o),
    .sw_batt_o(sw_batt_o)
  );

  swo_gating u_gate (
    .sel_q_i   (sel_q),
    .pf_ok_i   (flags_s.pf_ok),
    .backup_o  (backup_o),
    .pfo_o     (pfo_o),
    .pfcmp_en_o(pfcmp_en_o),
    .wdog_en_o (wdog_en_o),
    .rst_hold_o(rst_hold_o)
  );
endmodule

// File: rtl/swo_checker.sv
module swo_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic vcc_low_s,
  input logic vcc_over_s,
  input logic bat_over_s,
  input logic sw_main_o,
  input logic sw_batt_o,
  input logic backup_o,
  input logic pfo_o,
  input logic pfcmp_en_o,
  input logic wdog_en_o,
  input logic rst_hold_o
);
  assert_supply_ok_main_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_low_s |=> !backup_o);

  assert_enter_backup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_low_s && bat_over_s && !vcc_over_s) |=> backup_o);

  assert_return_main_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_low_s && vcc_over_s && !bat_over_s) |=> !backup_o);

  assert_window_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_low_s && !vcc_over_s && !bat_over_s) |=> (backup_o == $past(backup_o)));

  assert_conflict_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_low_s && vcc_over_s && bat_over_s) |=> (backup_o == $past(backup_o)));

  assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_main_o && sw_batt_o));

  assert_batt_after_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_batt_o) |-> !$past(sw_main_o));

  assert_main_after_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_main_o) |-> !$past(sw_batt_o));

  assert_batt_needs_backup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_batt_o |-> backup_o);

  assert_pfo_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_o |-> (!pfo_o && !pfcmp_en_o));

  assert_supervisor_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backup_o |-> (rst_hold_o && !wdog_en_o));

  assert_supervisor_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !backup_o |-> (!rst_hold_o && wdog_en_o && pfcmp_en_o));
endmodule

bind supply_switchover_ctrl swo_checker u_swo_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vcc_low_s (vcc_low_s),
  .vcc_over_s(vcc_over_s),
  .bat_over_s(bat_over_s),
  .sw_main_o (sw_main_o),
  .sw_batt_o (sw_batt_o),
  .backup_o  (backup_o),
  .pfo_o     (pfo_o),
  .pfcmp_en_o(pfcmp_en_o),
  .wdog_en_o (wdog_en_o),
  .rst_hold_o(rst_hold_o)
);

// File: tb/tb_supply_switchover_ctrl.sv
module tb_supply_switchover_ctrl;
  localparam int DEAD = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vcc_low = 1'b0, vcc_over = 1'b0, bat_over = 1'b0, pf_ok = 1'b0;
  logic sw_main, sw_batt, backup, pfo, pfcmp_en, wdog_en, rst_hold;

  int n_checks = 0;
  int n_fail   = 0;
  logic exp_batt = 1'b0;

  always #5 clk = ~clk;

  supply_switchover_ctrl #(.SYNC_STAGES(2), .DEAD_CYCLES(DEAD)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .vcc_low_i(vcc_low), .vcc_over_bat_i(vcc_over), .bat_over_vcc_i(bat_over), .pf_ok_i(pf_ok),
    .sw_main_o(sw_main), .sw_batt_o(sw_batt), .backup_o(backup), .pfo_o(pfo),
    .pfcmp_en_o(pfcmp_en), .wdog_en_o(wdog_en), .rst_hold_o(rst_hold)
  );

  function automatic logic [6:0] outs();
    return {sw_main, sw_batt, backup, pfo, pfcmp_en, wdog_en, rst_hold};
  endfunction

  // expected steady outputs for a selection and power-fail flag
  function automatic logic [6:0] exp_outs(logic batt, logic pf);
    return batt ? 7'b0110001 : {1'b1, 1'b0, 1'b0, pf, 1'b1, 1'b1, 1'b0};
  endfunction

  function automatic logic next_sel(logic prev, logic low, logic vo, logic bo);
    if (!low)          return 1'b0;
    if (bo && !vo)     return 1'b1;
    if (vo && !bo)     return 1'b0;
    return prev;
  endfunction

  function automatic string tag_of(logic low, logic vo, logic bo);
    if (!low)      return "R1";
    if (bo && !vo) return "R2";
    if (vo && !bo) return "R3";
    if (!vo && !bo) return "R4";
    return "R5";
  endfunction

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(logic low, logic vo, logic bo, logic pf, string req);
    vcc_low = low; vcc_over = vo; bat_over = bo; pf_ok = pf;
    exp_batt = next_sel(exp_batt, low, vo, bo);
    repeat (6) @(negedge clk);
    chk({req, "/R7/R8"}, outs(), exp_outs(exp_batt, pf));
  endtask

  // R6 monitor: overlap and dead-interval length
  int off_run = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (sw_main && sw_batt) begin
        n_checks++; n_fail++;
        $display("FAIL R6: overlap actual=11 expected=not 11");
      end else if (!sw_main && !sw_batt) begin
        off_run++;
      end else if (off_run > 0) begin
        n_checks++;
        if (off_run != DEAD) begin
          n_fail++;
          $display("FAIL R6: dead interval actual=%0d expected=%0d", off_run, DEAD);
        end
        off_run = 0;
      end
    end
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R9 in reset", outs(), 7'b1000110);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 after reset", outs(), 7'b1000110);

    // R10 latency: main -> battery
    vcc_low = 1; bat_over = 1; vcc_over = 0; pf_ok = 1;
    @(negedge clk); @(negedge clk);
    chk("R10 edge2 still main", outs(), 7'b1001110);
    @(negedge clk);
    chk("R10 edge3 backup, gap", outs(), 7'b0010001);
    @(negedge clk);
    chk("R10 edge4 battery on", outs(), 7'b0110001);
    exp_batt = 1'b1;

    // R4 hold on battery, R3 return, R4 hold on main
    apply(1, 0, 0, 1, "R4 hold batt");
    apply(1, 1, 0, 1, "R3 to main");
    apply(1, 0, 0, 0, "R4 hold main");
    // R5 conflicting flags from both sides
    apply(1, 1, 1, 1, "R5 hold main");
    apply(1, 0, 1, 0, "R2 to batt");
    apply(1, 1, 1, 1, "R5 hold batt");
    // R1 supply ok overrides battery flag
    apply(0, 0, 1, 1, "R1 override");
    apply(0, 0, 1, 0, "R7 pfo low");
    apply(1, 0, 1, 1, "R2 pfo forced");

    for (int i = 0; i < 300; i++) begin
      logic low, vo, bo, pf;
      int h;
      low = ($urandom % 10) < 7;
      h   = $urandom % 20;
      vo  = (h < 7) || (h == 19);
      bo  = (h >= 7 && h < 14) || (h == 19);
      pf  = $urandom % 2;
      apply(low, vo, bo, pf, tag_of(low, vo, bo));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule